// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 16-bit ports, called A and B, and can carry data in both directions. Each pin is modelled with separate input, output and output-enable signals instead of a true tri-state pin. Each direction has its own storage register and its own capture strobe. A select input chooses what that direction drives: either the word arriving live from the opposite port, or the word held in its register. Each direction also has an output enable. The A-to-B enable is active high. The B-to-A enable is active low.

The data word is split into byte lanes, and every lane has a full set of its own controls. A lane therefore acts as an independent byte transceiver, and tying the controls of all lanes together gives one word-wide transceiver. A bus-keeper model gives each port a resolved bus value:
- When an outside source drives a lane, the bus follows that source.
- When only this block drives the lane, the bus takes the block's output.
- When nothing drives the lane, the bus keeps its last level.

If both directions are enabled in live mode, each bus feeds the other, so the pair holds its value with no outside driver. The capture strobes are sampled on the system clock `clk`. A synchronous power-up reset clears all state and keeps the drivers off.

Top module: `bus_xcvr_reg`

## Requirements
- R1: For lane i (bits 8i+7..8i), `b_out` equals the resolved A bus when `sel_ab[i]` is 0, and the A-to-B stored byte when `sel_ab[i]` is 1.
- R2: For lane i, `a_out` equals the resolved B bus when `sel_ba[i]` is 0, and the B-to-A stored byte when `sel_ba[i]` is 1.
- R3: A stored byte loads the resolved bus of its source port at the first `clk` edge where its strobe (`stb_ab[i]` or `stb_ba[i]`) is seen high after being low. This happens whatever the select and enable levels are. At every other edge the stored byte is unchanged.
- R4: `b_oe[i]` is 1 exactly when `en_ab[i]` is 1, and `a_oe[i]` is 1 exactly when `en_ba_n[i]` is 0, outside the power-up window.
- R5: Each lane's outputs depend only on that lane's controls and data bits. Setting different selects per lane mixes stored and live bytes in one word.
- R6: A resolved bus lane equals the external input while its drive-valid bit is 1, and equals the keeper otherwise. At each `clk` edge the keeper loads the external value if it is driven, otherwise the block's own output if it is enabled, and otherwise it holds.
- R7: Suppose both selects are 0 and both directions are enabled, and an external value has been on A for one edge before it is released. Both resolved buses then keep that value for as long as no source changes.
- R8: Switching a select while the stored byte equals the live byte leaves the output unchanged in that cycle.
- R9: While `rst` is high, and up to the first `clk` edge after it falls, both enables are 0. Reset clears both stored words and both keepers to zero.
- R10: Outputs follow select, enable and live-bus changes in the same cycle, with no register stage in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high power-up reset |
| a_in | input | 16 | Value an external source places on the A bus |
| a_drv | input | 2 | Per-lane: external source is driving the A bus |
| b_in | input | 16 | Value an external source places on the B bus |
| b_drv | input | 2 | Per-lane: external source is driving the B bus |
| en_ab | input | 2 | Per-lane A-to-B driver enable, active high |
| en_ba_n | input | 2 | Per-lane B-to-A driver enable, active low |
| sel_ab | input | 2 | Per-lane A-to-B source: 0 live, 1 stored |
| sel_ba | input | 2 | Per-lane B-to-A source: 0 live, 1 stored |
| stb_ab | input | 2 | Per-lane A-to-B capture strobe (rising edge) |
| stb_ba | input | 2 | Per-lane B-to-A capture strobe (rising edge) |
| a_out | output | 16 | Data the block drives toward A |
| a_oe | output | 2 | Per-lane A driver enable |
| b_out | output | 16 | Data the block drives toward B |
| b_oe | output | 2 | Per-lane B driver enable |
| a_bus | output | 16 | Resolved A bus value with bus hold |
| b_bus | output | 16 | Resolved B bus value with bus hold |

## Verification
The bench builds the block with its defaults, two lanes of eight bits. Two lanes is the smallest width at which lane independence can be observed. It brings within reach words that mix a stored byte with a live byte, a capture into one lane only, and a bus that is driven in one lane while the other lane is held. The sixteen-bit width also lets the self-holding loop and the post-reset clearing be seen across both lanes at once.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((rise & $past(rise)) == '0)); // R3
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_rise,
  input  logic         sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] store_q;
  src_sel_e     src;

  always_ff @(posedge clk) begin
    if (rst)           store_q <= '0;
    else if (cap_rise) store_q <= din;
  end

  assign src  = src_sel_e'(sel);
  assign dout = (src == SRC_STORED) ? store_q : din;

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
    cap_rise |=> (store_q == $past(din))); // R3
  AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cap_rise |=> $stable(store_q)); // R3
  AST_SWITCH_NO_GLITCH: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sel) && $stable(din) && (store_q == din)) |-> (dout == din)); // R8
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_vld,
  input  logic [W-1:0] ext_data,
  input  logic         own_oe,
  input  logic [W-1:0] own_data,
  output logic [W-1:0] bus
);
  logic [W-1:0] keep_q;

  always_ff @(posedge clk) begin
    if (rst)          keep_q <= '0;
    else if (ext_vld) keep_q <= ext_data;
    else if (own_oe)  keep_q <= own_data;
  end

  assign bus = ext_vld ? ext_data : keep_q;

  AST_KEEP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!ext_vld && !own_oe) |=> $stable(bus) || ext_vld); // R6
  AST_KEEP_OWN: assert property (@(posedge clk) disable iff (rst)
    (!ext_vld && own_oe) |=> (ext_vld || bus == $past(own_data))); // R6
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DW    = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    a_in,
  input  logic [LANES-1:0] a_drv,
  input  logic [DW-1:0]    b_in,
  input  logic [LANES-1:0] b_drv,
  input  logic [LANES-1:0] en_ab,
  input  logic [LANES-1:0] en_ba_n,
  input  logic [LANES-1:0] sel_ab,
  input  logic [LANES-1:0] sel_ba,
  input  logic [LANES-1:0] stb_ab,
  input  logic [LANES-1:0] stb_ba,
  output logic [DW-1:0]    a_out,
  output logic [LANES-1:0] a_oe,
  output logic [DW-1:0]    b_out,
  output logic [LANES-1:0] b_oe,
  output logic [DW-1:0]    a_bus,
  output logic [DW-1:0]    b_bus
);
  logic             rdy_q;
  logic [LANES-1:0] rise_ab;
  logic [LANES-1:0] rise_ba;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  xcvr_rise_det #(.N(LANES)) u_rise_ab (
    .clk(clk), .rst(rst), .lvl(stb_ab), .rise(rise_ab));
  xcvr_rise_det #(.N(LANES)) u_rise_ba (
    .clk(clk), .rst(rst), .lvl(stb_ba), .rise(rise_ba));

  assign b_oe = en_ab & {LANES{rdy_q}};
  assign a_oe = ~en_ba_n & {LANES{rdy_q}};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LO = l * LANE_W;

    xcvr_path #(.W(LANE_W)) u_ab (
      .clk(clk), .rst(rst), .cap_rise(rise_ab[l]), .sel(sel_ab[l]),
      .din(a_bus[LO +: LANE_W]), .dout(b_out[LO +: LANE_W]));

    xcvr_path #(.W(LANE_W)) u_ba (
      .clk(clk), .rst(rst), .cap_rise(rise_ba[l]), .sel(sel_ba[l]),
      .din(b_bus[LO +: LANE_W]), .dout(a_out[LO +: LANE_W]));

    xcvr_keeper #(.W(LANE_W)) u_keep_a (
      .clk(clk), .rst(rst), .ext_vld(a_drv[l]), .ext_data(a_in[LO +: LANE_W]),
      .own_oe(a_oe[l]), .own_data(a_out[LO +: LANE_W]), .bus(a_bus[LO +: LANE_W]));

    xcvr_keeper #(.W(LANE_W)) u_keep_b (
      .clk(clk), .rst(rst), .ext_vld(b_drv[l]), .ext_data(b_in[LO +: LANE_W]),
      .own_oe(b_oe[l]), .own_data(b_out[LO +: LANE_W]), .bus(b_bus[LO +: LANE_W]));
  end

  AST_PWRUP_DRIVERS_OFF: assert property (@(posedge clk)
    rst |=> (a_oe == '0 && b_oe == '0)); // R9
  AST_AB_ENABLE_POL: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (b_oe == en_ab)); // R4
  AST_BA_ENABLE_POL: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (a_oe == ~en_ba_n)); // R4
endmodule

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;
  localparam int LW = 8;
  localparam int NL = 2;
  localparam int DW = LW * NL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] a_in = '0, b_in = '0;
  logic [NL-1:0] a_drv = '0, b_drv = '0, en_ab = '0, en_ba_n = '1;
  logic [NL-1:0] sel_ab = '0, sel_ba = '0, stb_ab = '0, stb_ba = '0;
  logic [DW-1:0] a_out, b_out, a_bus, b_bus;
  logic [NL-1:0] a_oe, b_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_xcvr_reg #(.LANE_W(LW), .LANES(NL)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_drv(a_drv), .b_in(b_in), .b_drv(b_drv),
    .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .stb_ab(stb_ab), .stb_ba(stb_ba), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe), .a_bus(a_bus), .b_bus(b_bus));

  typedef struct packed {
    logic [15:0] a;  logic [1:0] adrv;
    logic [15:0] b;  logic [1:0] bdrv;
    logic [1:0] eab; logic [1:0] eban;
    logic [1:0] sab; logic [1:0] sba;
    logic [1:0] cab; logic [1:0] cba;
    logic [15:0] xb; logic [1:0] xboe;
    logic [15:0] xa; logic [1:0] xaoe;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 2'b11, 16'h0000, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00,
      16'h1234, 2'b11, 16'h0000, 2'b00},
    '{16'hABCD, 2'b11, 16'h0000, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00,
      16'hABCD, 2'b11, 16'h0000, 2'b00},
    '{16'h5555, 2'b11, 16'h0000, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00,
      16'hABCD, 2'b11, 16'h0000, 2'b00},
    '{16'h5555, 2'b11, 16'h0000, 2'b11, 2'b11, 2'b11, 2'b01, 2'b00, 2'b00, 2'b00,
      16'h55CD, 2'b11, 16'h0000, 2'b00},
    '{16'h5555, 2'b11, 16'h9876, 2'b11, 2'b11, 2'b10, 2'b00, 2'b11, 2'b00, 2'b01,
      16'h5555, 2'b11, 16'h0076, 2'b01},
    '{16'h1357, 2'b11, 16'h9876, 2'b11, 2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b00,
      16'h1357, 2'b00, 16'h0076, 2'b00},
    '{16'h0000, 2'b11, 16'h9876, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00,
      16'h1357, 2'b11, 16'h0076, 2'b00}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R9: drivers stay off during reset even with both enables asserted
    en_ab = 2'b11; en_ba_n = 2'b00;
    repeat (3) tick();
    chk("R9", "b_oe in reset", 32'(b_oe), 32'h0);
    chk("R9", "a_oe in reset", 32'(a_oe), 32'h0);
    @(negedge clk); rst = 1'b0; sel_ab = 2'b11; sel_ba = 2'b11;
    #1;
    chk("R9", "b_oe before first edge", 32'(b_oe), 32'h0);
    tick();
    chk("R9", "stored A-to-B cleared", 32'(b_out), 32'h0);
    chk("R9", "stored B-to-A cleared", 32'(a_out), 32'h0);
    chk("R4", "b_oe after reset", 32'(b_oe), 32'h3);
    chk("R4", "a_oe after reset", 32'(a_oe), 32'h3);

    // Vector table: R1 R2 R3 R4 R5 R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a_in = VECS[i].a; a_drv = VECS[i].adrv; b_in = VECS[i].b; b_drv = VECS[i].bdrv;
      en_ab = VECS[i].eab; en_ba_n = VECS[i].eban;
      sel_ab = VECS[i].sab; sel_ba = VECS[i].sba;
      stb_ab = VECS[i].cab; stb_ba = VECS[i].cba;
      tick();
      chk("R1", $sformatf("vec %0d b_out", i), 32'(b_out), 32'(VECS[i].xb));
      chk("R4", $sformatf("vec %0d b_oe", i), 32'(b_oe), 32'(VECS[i].xboe));
      chk("R2", $sformatf("vec %0d a_out", i), 32'(a_out), 32'(VECS[i].xa));
      chk("R4", $sformatf("vec %0d a_oe", i), 32'(a_oe), 32'(VECS[i].xaoe));
    end

    // R10: live change seen in the same cycle, no clock edge
    @(negedge clk); sel_ab = 2'b00; a_in = 16'h2468;
    #1;
    chk("R10", "live path same cycle", 32'(b_out), 32'h2468);

    // R8: switching select while stored equals live keeps output steady
    @(negedge clk); a_in = 16'h1357;
    #1;
    chk("R8", "before switch", 32'(b_out), 32'h1357);
    sel_ab = 2'b11;
    #1;
    chk("R8", "after switch", 32'(b_out), 32'h1357);

    // R7: self-holding loop in live mode with both directions on
    @(negedge clk);
    sel_ab = 2'b00; sel_ba = 2'b00; en_ab = 2'b11; en_ba_n = 2'b00;
    a_in = 16'hC3A5; a_drv = 2'b11; b_drv = 2'b00;
    tick();
    @(negedge clk); a_drv = 2'b00; a_in = 16'h0000;
    repeat (4) tick();
    chk("R7", "a_bus holds", 32'(a_bus), 32'hC3A5);
    chk("R7", "b_bus holds", 32'(b_bus), 32'hC3A5);
    chk("R7", "b_out loop", 32'(b_out), 32'hC3A5);

    // R6: undriven bus keeps its level, then one lane driven
    @(negedge clk); en_ab = 2'b00; en_ba_n = 2'b11; a_in = 16'hFFFF;
    repeat (3) tick();
    chk("R6", "a_bus kept", 32'(a_bus), 32'hC3A5);
    @(negedge clk); a_drv = 2'b01;
    #1;
    chk("R6", "lane0 driven", 32'(a_bus), 32'hC3FF);
    tick();
    @(negedge clk); a_drv = 2'b00;
    tick();
    chk("R6", "lane0 kept new", 32'(a_bus), 32'hC3FF);

    // R9: mid-run reset clears stores and keepers
    @(negedge clk); rst = 1'b1; en_ab = 2'b11; en_ba_n = 2'b00;
    sel_ab = 2'b11; sel_ba = 2'b11;
    tick();
    chk("R9", "oe off in reset", 32'({a_oe, b_oe}), 32'h0);
    @(negedge clk); rst = 1'b0;
    tick();
    chk("R9", "b_out stored zero", 32'(b_out), 32'h0);
    chk("R9", "a_bus keeper zero", 32'(a_bus), 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule